// File: doc/BRIEF.md
# External/Status Change Interrupt Latch

This block watches the modem and line-status inputs of two serial channels: break/abort, transmit underrun/end-of-message, clear-to-send, sync/hunt, carrier detect and baud-counter zero count. It also carries the transmit-buffer-empty and receive-character-available flags. Each input goes through a two-flop synchronizer. The block then shows the levels in an 8-bit status byte per channel. An enabled source that changes level in either direction sets a per-channel latch. While the latch is set, the interrupting bits of the status byte keep the values they had when the change happened. Software reads the frozen byte and then clears the latch with a reset-status command.

Configuration arrives through a single write port that carries a channel select, a 4-bit register address and a data byte. Each channel has its own source mask and its own status-interrupt enable. One master interrupt enable serves both channels. A change that happens while the latch is held is kept. If the live level differs from the frozen value once the latch is released, the request is raised again at once.

Top module: `ext_status_irq`

## Requirements
- R1: Out of reset, every status byte, the pending byte and `irq` are 0. With no latch held, status byte bit i shows `ext_in` bit i of that channel two clock edges after the input changes. Bit layout: 7 break, 6 underrun/EOM, 5 CTS, 4 sync/hunt, 3 DCD, 2 transmit empty, 1 zero count, 0 receive available.
- R2: When a source whose mask bit is 1 changes level in either direction, the latch of that channel is set on the edge after the change reaches the status byte.
- R3: A change on a source whose mask bit is 0 never sets the latch. Bits 2 and 0 never set the latch, whatever the mask holds.
- R4: While a latch is held, status bits 7:3 and 1 keep the values captured when it was set, and bits 2 and 0 keep following the inputs.
- R5: A write to address 0 whose data bits 5:3 equal 3'b010 releases that channel's latch on the write edge. Other command codes leave the latch unchanged.
- R6: If an enabled source's live level differs from its frozen value when the latch is released, the latch is set again on the next edge and captures the live values.
- R7: Pending byte bit 3 equals channel 0's latch ANDed with its status-interrupt enable, and bit 0 does the same for channel 1. Every other pending bit is 0. The status-interrupt enable is data bit 0 written to address 1. The latch forms whatever that enable holds.
- R8: `irq` is 1 exactly when the master enable and at least one pending bit are both 1. The master enable is data bit 3 written to address 9 and is shared by both channels.
- R9: The two channels are independent. Writes to addresses 0, 1 and 15 act only on the channel that `wr_ch` selects. The mask is the full data byte written to address 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | 16 | Raw status inputs, channel 0 in bits 7:0, channel 1 in bits 15:8 |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel that the write addresses |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| status_byte | output | 16 | Status bytes, channel 0 in bits 7:0 |
| pend_byte | output | 8 | Status-pending flags: bit 3 is channel 0, bit 0 is channel 1 |
| irq | output | 1 | Status interrupt request |

## Verification
A latch that sets when it should not shows up within one cycle as a frozen status byte and as a pending bit. A latch that fails to set shows up in the same way, as a missing pending bit and a byte that keeps tracking. A corrupted snapshot becomes visible on the very edge the latch is set. Comparing the status byte against the bench's own model on every clock therefore catches it before software could read it. A change that is lost during the hold stays hidden until the release. For that reason the release cases are checked one cycle after the reset command, when the request has to come back.

// File: rtl/esl_pkg.sv
package esl_pkg;
  localparam int NCH = 2;
  localparam int SW  = 8;
  localparam int CHW = 1;
  localparam int AW  = 4;

  // status-byte bits that may raise a change request
  localparam logic [SW-1:0] SRC_MASK = 8'hFA;

  localparam logic [AW-1:0] ADDR_CMD  = 4'd0;
  localparam logic [AW-1:0] ADDR_IE   = 4'd1;
  localparam logic [AW-1:0] ADDR_MIE  = 4'd9;
  localparam logic [AW-1:0] ADDR_MASK = 4'd15;
  localparam logic [2:0]    CMD_RST_STAT = 3'b010;
  localparam int IE_BIT  = 0;
  localparam int MIE_BIT = 3;

  // pending-byte position for a channel
  function automatic int pend_pos(input int ch);
    return (ch == 0) ? 3 : 0;
  endfunction

  function automatic logic is_rst_stat(input logic [AW-1:0] a, input logic [SW-1:0] d);
    return (a == ADDR_CMD) && (d[5:3] == CMD_RST_STAT);
  endfunction

  // frozen interrupting bits while held, live elsewhere
  function automatic logic [SW-1:0] merge_status(input logic held,
                                                 input logic [SW-1:0] snap,
                                                 input logic [SW-1:0] live);
    return held ? ((snap & SRC_MASK) | (live & ~SRC_MASK)) : live;
  endfunction
endpackage

// File: rtl/esl_sync.sv
module esl_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r <= '0;
    end else begin
      r[0] <= d;
      for (int i = 1; i < STAGES; i++) r[i] <= r[i-1];
    end
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/esl_cfg.sv
module esl_cfg
  import esl_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [CHW-1:0]          wr_ch,
  input  logic [AW-1:0]           wr_addr,
  input  logic [SW-1:0]           wr_data,
  output logic [NCH-1:0][SW-1:0]  mask,
  output logic [NCH-1:0]          sie,
  output logic                    mie,
  output logic [NCH-1:0]          rst_cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mie <= 1'b0;
    else if (wr_en && wr_addr == ADDR_MIE) mie <= wr_data[MIE_BIT];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel;
    assign sel        = wr_en && (wr_ch == CHW'(c));
    assign rst_cmd[c] = sel && is_rst_stat(wr_addr, wr_data);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask[c] <= '0;
        sie[c]  <= 1'b0;
      end else if (sel) begin
        if (wr_addr == ADDR_MASK) mask[c] <= wr_data;
        if (wr_addr == ADDR_IE)   sie[c]  <= wr_data[IE_BIT];
      end
    end
  end
endmodule

// File: rtl/esl_chan.sv
module esl_chan
  import esl_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] live,
  input  logic [SW-1:0] mask,
  input  logic          rst_cmd,
  output logic          held,
  output logic          evt,
  output logic [SW-1:0] status
);
  logic [SW-1:0] snap;

  // while free snap is last cycle's level (edge detect); while held it is
  // the frozen level, so a later difference survives until release
  assign evt = |((live ^ snap) & mask & SRC_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      snap <= '0;
    end else if (held) begin
      if (rst_cmd) held <= 1'b0;
    end else begin
      if (evt) held <= 1'b1;
      snap <= live;
    end
  end

  assign status = merge_status(held, snap, live);
endmodule

// File: rtl/ext_status_irq.sv
module ext_status_irq
  import esl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*SW-1:0] ext_in,
  input  logic              wr_en,
  input  logic [CHW-1:0]    wr_ch,
  input  logic [AW-1:0]     wr_addr,
  input  logic [SW-1:0]     wr_data,
  output logic [NCH*SW-1:0] status_byte,
  output logic [SW-1:0]     pend_byte,
  output logic              irq
);
  logic [NCH*SW-1:0]       live_w;
  logic [NCH-1:0][SW-1:0]  mask_w;
  logic [NCH-1:0]          sie_w;
  logic                    mie_w;
  logic [NCH-1:0]          rst_cmd_w;
  logic [NCH-1:0]          held_w;
  logic [NCH-1:0]          evt_w;

  esl_sync #(.WIDTH(NCH*SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_in), .q(live_w)
  );

  esl_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .mask(mask_w), .sie(sie_w), .mie(mie_w), .rst_cmd(rst_cmd_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    esl_chan u_chan (
      .clk(clk), .rst_n(rst_n),
      .live(live_w[c*SW +: SW]), .mask(mask_w[c]), .rst_cmd(rst_cmd_w[c]),
      .held(held_w[c]), .evt(evt_w[c]), .status(status_byte[c*SW +: SW])
    );
  end

  always_comb begin
    pend_byte = '0;
    for (int c = 0; c < NCH; c++) pend_byte[pend_pos(c)] = held_w[c] & sie_w[c];
  end

  assign irq = mie_w & (|pend_byte);
endmodule

// File: rtl/esl_chk.sv
module esl_chk
  import esl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    held,
  input logic [NCH-1:0]    evt,
  input logic [NCH-1:0]    rst_cmd,
  input logic              mie,
  input logic [NCH*SW-1:0] status_byte,
  input logic [SW-1:0]     pend_byte,
  input logic              irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r2_event_latches: assert property (@(posedge clk) disable iff (!rst_n)
      evt[c] && !held[c] |=> held[c]);
    a_r4_hold_until_reset: assert property (@(posedge clk) disable iff (!rst_n)
      held[c] && !rst_cmd[c] |=> held[c]);
    a_r4_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
      held[c] && !rst_cmd[c] |=> $stable(status_byte[c*SW +: SW] & SRC_MASK));
    a_r5_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
      held[c] && rst_cmd[c] |=> !held[c]);
    a_r7_pend_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
      pend_byte[pend_pos(c)] |-> held[c]);
  end

  a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_byte & 8'hF6) == 8'h00);
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mie && (pend_byte != 8'h00));
endmodule

bind ext_status_irq esl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .held(held_w), .evt(evt_w), .rst_cmd(rst_cmd_w),
  .mie(mie_w), .status_byte(status_byte), .pend_byte(pend_byte), .irq(irq)
);

// File: tb/test_ext_status_irq.sv
`timescale 1ns/1ps
module test_ext_status_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ext_in = '0;
  logic        wr_en = 1'b0;
  logic [0:0]  wr_ch = '0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] status_byte;
  logic [7:0]  pend_byte;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_status_irq i_ext_status_irq (
    .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_addr(wr_addr), .wr_data(wr_data), .status_byte(status_byte),
    .pend_byte(pend_byte), .irq(irq)
  );

  // behavioural reference: input delay line, per-channel hold flag and picture
  logic [7:0] dly [2][$];
  logic [7:0] pic [2];
  bit         hold [2];
  logic [7:0] msk [2];
  bit         ien [2];
  bit         men;

  function automatic logic [7:0] seen(int c);
    return dly[c][0];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        dly[c] = '{8'h00, 8'h00};
        pic[c] = 8'h00; hold[c] = 0; msk[c] = 8'h00; ien[c] = 0;
      end
      men = 0;
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit cmd;
        logic [7:0] cur;
        cur = seen(c);
        cmd = wr_en && (wr_ch == c[0]) && (wr_addr == 4'd0) && (wr_data[5:3] == 3'b010);
        if (hold[c]) begin
          if (cmd) hold[c] = 0;
        end else begin
          if (((cur ^ pic[c]) & msk[c] & 8'hFA) != 8'h00) hold[c] = 1;
          pic[c] = cur;
        end
        if (wr_en && wr_ch == c[0] && wr_addr == 4'd1)  ien[c] = wr_data[0];
        if (wr_en && wr_ch == c[0] && wr_addr == 4'd15) msk[c] = wr_data;
        void'(dly[c].pop_front());
        dly[c].push_back(ext_in[c*8 +: 8]);
      end
      if (wr_en && wr_addr == 4'd9) men = wr_data[3];
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] ep;
      ep = 8'h00;
      ep[3] = hold[0] & ien[0];
      ep[0] = hold[1] & ien[1];
      for (int c = 0; c < 2; c++) begin
        logic [7:0] es;
        es = hold[c] ? ((pic[c] & 8'hFA) | (seen(c) & 8'h05)) : seen(c);
        check(hold[c] ? "R4 status" : "R1 status", {8'h00, status_byte[c*8 +: 8]}, {8'h00, es});
      end
      check("R7 pending", {8'h00, pend_byte}, {8'h00, ep});
      check("R8 irq", {15'h0, irq}, {15'h0, men & (ep != 8'h00)});
    end
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int c, logic [3:0] a, logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_ch = c[0]; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic drive(int c, logic [7:0] v);
    ext_in[c*8 +: 8] = v;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    idle(3);
    check("R1 reset status", status_byte, 16'h0000);
    check("R1 reset pend", {8'h00, pend_byte}, 16'h0000);
    check("R1 reset irq", {15'h0, irq}, 16'h0000);
    rst_n = 1'b1;
    idle(2);

    wr(0, 4'd9, 8'h08);
    wr(0, 4'd1, 8'h01);
    wr(0, 4'd15, 8'h20);

    // R1/R3: bits 2 and 0 are live and never latch
    drive(0, 8'h05); idle(3);
    check("R1 live status", {8'h00, status_byte[7:0]}, 16'h0005);
    check("R3 flags no latch", {8'h00, pend_byte}, 16'h0000);

    // R2 rising edge on enabled CTS
    drive(0, 8'h25); idle(4);
    check("R2 rise latch", {8'h00, pend_byte}, 16'h0008);
    check("R8 irq on", {15'h0, irq}, 16'h0001);

    // R4 frozen while held, bits 2/0 live
    drive(0, 8'h01); idle(4);
    check("R4 frozen", {8'h00, status_byte[7:0]}, 16'h0021);

    // R5 other code ignored
    wr(0, 4'd0, 8'h28); idle(2);
    check("R5 other code", {8'h00, pend_byte}, 16'h0008);

    // R6 change during hold re-raises
    wr(0, 4'd0, 8'h10); idle(3);
    check("R6 re-raise", {8'h00, pend_byte}, 16'h0008);
    check("R6 new snapshot", {8'h00, status_byte[7:0]}, 16'h0001);

    // R5 clean release
    wr(0, 4'd0, 8'h10); idle(3);
    check("R5 release", {8'h00, pend_byte}, 16'h0000);

    // R3 masked DCD
    drive(0, 8'h09); idle(4);
    check("R3 masked", {8'h00, pend_byte}, 16'h0000);
    check("R3 masked live", {8'h00, status_byte[7:0]}, 16'h0009);

    // R2 falling edge
    drive(0, 8'h29); idle(4);
    wr(0, 4'd0, 8'h10); idle(3);
    drive(0, 8'h09); idle(4);
    check("R2 fall latch", {8'h00, pend_byte}, 16'h0008);
    wr(0, 4'd0, 8'h10); idle(3);

    // R7 channel enable off: latch still forms, no pending
    wr(0, 4'd1, 8'h00);
    drive(0, 8'h29); idle(4);
    check("R7 sie off", {8'h00, pend_byte}, 16'h0000);
    drive(0, 8'h09); idle(4);
    check("R7 latched silently", {8'h00, status_byte[7:0]}, 16'h0029);
    wr(0, 4'd1, 8'h01); idle(1);
    check("R7 sie on", {8'h00, pend_byte}, 16'h0008);

    // R8 master enable
    wr(0, 4'd9, 8'h00); idle(2);
    check("R8 mie off", {15'h0, irq}, 16'h0000);
    wr(1, 4'd9, 8'h08); idle(2);
    check("R8 mie shared", {15'h0, irq}, 16'h0001);
    wr(0, 4'd0, 8'h10); idle(3);
    wr(0, 4'd0, 8'h10); idle(3);
    check("R5 cleared", {8'h00, pend_byte}, 16'h0000);

    // R9 channel 1 independent
    wr(1, 4'd1, 8'h01);
    wr(1, 4'd15, 8'h02);
    drive(1, 8'h02); idle(4);
    check("R9 ch1 pend", {8'h00, pend_byte}, 16'h0001);
    wr(0, 4'd0, 8'h10); idle(3);
    check("R9 ch0 cmd no effect", {8'h00, pend_byte}, 16'h0001);
    wr(1, 4'd0, 8'h10); idle(3);
    check("R9 ch1 release", {8'h00, pend_byte}, 16'h0000);

    // R2/R3 sweep of every bit on channel 1, enabled and masked
    for (int b = 0; b < 8; b++) begin
      for (int en = 0; en < 2; en++) begin
        logic [7:0] bitv;
        bitv = 8'h01 << b;
        wr(1, 4'd15, en ? bitv : ~bitv);
        drive(1, ext_in[15:8] ^ bitv); idle(4);
        check(en ? "R2 sweep" : "R3 sweep", {8'h00, pend_byte},
              {8'h00, 7'h00, (en != 0) && ((8'hFA & bitv) != 8'h00)});
        wr(1, 4'd0, 8'h10); idle(3);
      end
    end

    idle(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule